// File: doc/BRIEF.md
# Single-Precision Result Rounding Unit

This block turns an unrounded single-precision intermediate value into a final IEEE-754 single-precision word. The intermediate value has a sign, a biased exponent that may exceed the normal range, a 24-bit mantissa that includes the hidden one, three extra low bits, and a tag that marks it as an ordinary number, zero, infinity or NaN. The block rounds the value exactly once. A fused multiply-accumulate result therefore passes through one rounding step only. The block also raises the inexact, overflow and underflow cause bits.

A small control/status register holds the 2-bit rounding mode, three enable bits, three sticky flag bits and four cause bits. The fourth cause bit is an error bit, and it has no enable or flag partner. An exception request is raised together with each result when an enabled cause fires or when the error bit is set. A result that raises the exception leaves the sticky flags untouched. The arithmetic units write into the block with a one-cycle valid pulse, and software reads and writes the register directly.

Top module: `fp_round_unit`

## Requirements
- R1: Mode code 00 rounds to nearest. When the three extra bits {g,r,s} equal exactly 100 (a tie), the result is the neighbour whose mantissa LSB is 0.
- R2: Mode code 01 rounds toward zero, so the three extra bits are discarded.
- R3: Under mode 00, rounding up with a mantissa carry-out increments the exponent. If the exponent reaches 255 (or the input exponent is already 255 or more), the result is signed infinity, with the overflow and inexact causes set.
- R4: Under mode 01, an exponent of 255 or more gives the largest finite magnitude with the input sign (exponent 254, fraction all ones), with the overflow and inexact causes set.
- R5: The inexact cause is set exactly when any of the three extra bits is 1, or when overflow or underflow occurs. Every operation rewrites all four cause bits.
- R6: An ordinary number with biased exponent 0 becomes a zero of the same sign, with the underflow and inexact causes set.
- R7: The zero and infinity tags pass their signed value through. The NaN tag gives the quiet NaN 0x7FC00000. None of these tags raises O, U or I.
- R8: Mode codes 10 and 11 are reserved. They round toward zero and set the error cause.
- R9: The result, the exception request and the new cause bits appear one cycle after the valid pulse. The request is 1 when the error cause is set or when any O/U/I cause has its enable bit set.
- R10: When the request is 0, the O/U/I causes are ORed into the sticky flags. When the request is 1, the flags keep their value.
- R11: The register fields are mode [1:0], flags {O,U,I} [4:2], enables {O,U,I} [7:5] and causes {E,O,U,I} [11:8]. Bits 12 to 31, including bits 22 to 31, always read 0 whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One-cycle pulse presenting an intermediate value |
| in_sign | input | 1 | Sign of the intermediate value |
| in_exp | input | 9 | Biased exponent; 255 and above means out of range |
| in_mant | input | 24 | Mantissa including the hidden bit |
| in_grs | input | 3 | Guard, round, sticky bits, guard in bit 2 |
| in_tag | input | 2 | 00 number, 01 zero, 10 infinity, 11 NaN |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data |
| out_valid | output | 1 | Result valid |
| out_result | output | 32 | Rounded single-precision word |
| out_exc | output | 1 | Exception request for this result |

## Verification
The bench builds the block with its default widths of an 8-bit exponent and a 23-bit fraction, so the single-precision boundaries can be reached directly. These are the carry-out from an all-ones mantissa, a carry into exponent 255, an intermediate exponent of 254 that holds under truncation, and the saturated 0x7F7FFFFF/0xFF7FFFFF words. A reference model in the bench does the rounding on whole integers and predicts the result, the causes, the exception request and the sticky flags for each operation. It covers both tie directions, both reserved codes, and exceptions with the enable bits set.

// File: rtl/fp_round_unit.sv
module fp_round_unit #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      in_sign,
  input  logic [EXP_W:0]            in_exp,
  input  logic [FRAC_W:0]           in_mant,
  input  logic [2:0]                in_grs,
  input  logic [1:0]                in_tag,
  input  logic                      csr_we,
  input  logic [31:0]               csr_wdata,
  output logic [31:0]               csr_rdata,
  output logic                      out_valid,
  output logic [EXP_W+FRAC_W:0]     out_result,
  output logic                      out_exc
);
  localparam int MANT_W  = FRAC_W + 1;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam logic [1:0] TAG_NUM = 2'b00, TAG_ZERO = 2'b01, TAG_INF = 2'b10;

  logic [1:0] mode_q;
  logic [2:0] flag_q, en_q;
  logic [3:0] cause_q;

  wire rz = (mode_q != 2'b00);
  wire g  = in_grs[2];
  wire r  = in_grs[1];
  wire s  = in_grs[0];
  wire up = !rz && g && (r || s || in_mant[0]);

  wire [MANT_W:0]  msum = {1'b0, in_mant} + {{MANT_W{1'b0}}, up};
  wire             cout = msum[MANT_W];
  wire [EXP_W+1:0] esum = {1'b0, in_exp} + {{(EXP_W+1){1'b0}}, cout};
  wire [FRAC_W-1:0] frac_n = cout ? msum[FRAC_W:1] : msum[FRAC_W-1:0];
  wire ovf = (esum >= (EXP_W+2)'(EXP_MAX));
  wire unf = (in_exp == '0);

  logic [WORD_W-1:0] res_n;
  logic c_o, c_u, c_i;

  always_comb begin
    res_n = '0;
    c_o = 1'b0;
    c_u = 1'b0;
    c_i = 1'b0;
    case (in_tag)
      TAG_ZERO: res_n = {in_sign, {(WORD_W-1){1'b0}}};
      TAG_INF:  res_n = {in_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      TAG_NUM: begin
        if (unf) begin
          res_n = {in_sign, {(WORD_W-1){1'b0}}};
          c_u = 1'b1;
          c_i = 1'b1;
        end else if (ovf) begin
          c_o = 1'b1;
          c_i = 1'b1;
          if (rz) res_n = {in_sign, EXP_W'(EXP_MAX - 1), {FRAC_W{1'b1}}};
          else    res_n = {in_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else begin
          res_n = {in_sign, esum[EXP_W-1:0], frac_n};
          c_i = |in_grs;
        end
      end
      default:  res_n = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    endcase
  end

  wire [3:0] cause_n = {mode_q[1], c_o, c_u, c_i};
  wire       exc_n   = cause_n[3] || |(cause_n[2:0] & en_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= '0;
      flag_q     <= '0;
      en_q       <= '0;
      cause_q    <= '0;
      out_valid  <= 1'b0;
      out_result <= '0;
      out_exc    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (csr_we) begin
        mode_q <= csr_wdata[1:0];
        en_q   <= csr_wdata[7:5];
      end
      if (in_valid) begin
        out_result <= res_n;
        out_exc    <= exc_n;
        cause_q    <= cause_n;
        if (!exc_n) flag_q <= flag_q | cause_n[2:0];
      end else begin
        out_exc <= 1'b0;
        if (csr_we) begin
          flag_q  <= csr_wdata[4:2];
          cause_q <= csr_wdata[11:8];
        end
      end
    end
  end

  assign csr_rdata = {20'h0, cause_q, en_q, flag_q, mode_q};

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_exc) |-> (flag_q == $past(flag_q)));
  p_flags_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(csr_we) |-> ((flag_q & $past(flag_q)) == $past(flag_q)));
  p_rz_no_inf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode_q) == 2'b01 && $past(in_tag) == TAG_NUM)
      |-> (out_result[WORD_W-2:FRAC_W] != {EXP_W{1'b1}}));
  p_reserved_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode_q[1])) |-> (cause_q[3] && out_exc));
endmodule

// File: tb/test_fp_round_unit.sv
module test_fp_round_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sign = 1'b0;
  logic [8:0]  in_exp = '0;
  logic [23:0] in_mant = '0;
  logic [2:0]  in_grs = '0;
  logic [1:0]  in_tag = '0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata, out_result;
  logic        out_valid, out_exc;

  fp_round_unit i_fp_round_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
    .in_exp(in_exp), .in_mant(in_mant), .in_grs(in_grs), .in_tag(in_tag),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .out_valid(out_valid), .out_result(out_result), .out_exc(out_exc));

  always #4 clk = ~clk;

  typedef struct {
    logic [31:0] res;
    logic        exc;
    logic [3:0]  cause;
    logic [2:0]  flags;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  logic [1:0] m_mode = '0;
  logic [2:0] m_en = '0, m_flags = '0;
  bit done = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  function automatic logic [35:0] model(logic sg, logic [8:0] e, logic [23:0] m,
                                        logic [2:0] grs, logic [1:0] tg, logic [1:0] md);
    longint full, qv, rem, ev;
    logic o, u, i;
    logic [31:0] w;
    o = 0; u = 0; i = 0;
    if (tg == 2'b01) w = {sg, 31'h0};
    else if (tg == 2'b10) w = {sg, 31'h7F800000};
    else if (tg == 2'b11) w = 32'h7FC00000;
    else if (e == 0) begin w = {sg, 31'h0}; u = 1; i = 1; end
    else begin
      full = longint'({m, grs});
      qv = full / 8;
      rem = full % 8;
      ev = longint'(e);
      i = (rem != 0);
      if (md == 2'b00 && (rem > 4 || (rem == 4 && qv % 2 == 1))) qv = qv + 1;
      if (qv == 64'd16777216) begin qv = qv / 2; ev = ev + 1; end
      if (ev >= 255) begin
        o = 1; i = 1;
        w = (md == 2'b00) ? {sg, 31'h7F800000} : {sg, 31'h7F7FFFFF};
      end else w = {sg, ev[7:0], qv[22:0]};
    end
    return {md[1], o, u, i, w};
  endfunction

  task automatic op(string tag, logic sg, logic [8:0] e, logic [23:0] m,
                    logic [2:0] grs, logic [1:0] tg);
    item_t it;
    logic [35:0] r;
    r = model(sg, e, m, grs, tg, m_mode);
    it.res = r[31:0];
    it.cause = r[35:32];
    it.exc = r[35] || |(r[34:32] & m_en);
    if (!it.exc) m_flags = m_flags | r[34:32];
    it.flags = m_flags;
    it.tag = tag;
    q.push_back(it);
    in_valid = 1; in_sign = sg; in_exp = e; in_mant = m; in_grs = grs; in_tag = tg;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wr(logic [1:0] md, logic [2:0] fl, logic [2:0] en, logic [3:0] ca);
    csr_we = 1;
    csr_wdata = {20'hFFFFF, ca, en, fl, md};
    @(negedge clk);
    csr_we = 0;
    m_mode = md; m_en = en; m_flags = fl;
    check("R11 readback", csr_rdata, {20'h0, ca, en, fl, md});
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      item_t it;
      if (q.size() == 0) begin
        check("R9 unexpected result", 32'h1, 32'h0);
      end else begin
        it = q.pop_front();
        check({it.tag, " result"}, out_result, it.res);
        check({it.tag, " R9 exc"}, {31'h0, out_exc}, {31'h0, it.exc});
        check({it.tag, " R5 cause"}, {28'h0, csr_rdata[11:8]}, {28'h0, it.cause});
        check({it.tag, " R10 flags"}, {29'h0, csr_rdata[4:2]}, {29'h0, it.flags});
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R11 reset csr", csr_rdata, 32'h0);
    check("R9 reset valid", {31'h0, out_valid}, 32'h0);
    csr_we = 1; csr_wdata = 32'hFFFFFFFF;
    @(negedge clk);
    csr_we = 0;
    check("R11 upper bits zero", csr_rdata, 32'h00000FFF);
    wr(2'b00, 3'b000, 3'b000, 4'h0);
    op("R1 exact",          0, 9'd127, 24'h800000, 3'b000, 2'b00);
    op("R1 tie even stays", 0, 9'd127, 24'h800000, 3'b100, 2'b00);
    op("R1 tie odd up",     0, 9'd127, 24'h800001, 3'b100, 2'b00);
    op("R1 above half",     1, 9'd127, 24'h800000, 3'b101, 2'b00);
    op("R1 below half",     0, 9'd127, 24'h800000, 3'b011, 2'b00);
    op("R3 carry out",      0, 9'd127, 24'hFFFFFF, 3'b110, 2'b00);
    op("R3 carry to inf",   1, 9'd254, 24'hFFFFFF, 3'b100, 2'b00);
    op("R3 big exp inf",    0, 9'd300, 24'h800000, 3'b000, 2'b00);
    op("R6 underflow",      1, 9'd0,   24'h800000, 3'b000, 2'b00);
    op("R7 zero tag",       1, 9'd5,   24'h123456, 3'b111, 2'b01);
    op("R7 inf tag",        0, 9'd5,   24'h123456, 3'b111, 2'b10);
    op("R7 nan tag",        1, 9'd5,   24'h123456, 3'b111, 2'b11);
    op("R5 exact clears",   0, 9'd200, 24'hABCDEF, 3'b000, 2'b00);
    repeat (3) @(negedge clk);
    wr(2'b01, 3'b000, 3'b000, 4'h0);
    op("R2 truncate",       0, 9'd127, 24'h800001, 3'b111, 2'b00);
    op("R2 no carry",       1, 9'd254, 24'hFFFFFF, 3'b111, 2'b00);
    op("R4 saturate pos",   0, 9'd260, 24'h800000, 3'b000, 2'b00);
    op("R4 saturate neg",   1, 9'd255, 24'hFFFFFF, 3'b100, 2'b00);
    repeat (3) @(negedge clk);
    wr(2'b00, 3'b000, 3'b001, 4'h0);
    op("R10 enabled inexact", 0, 9'd127, 24'h800000, 3'b001, 2'b00);
    op("R10 overflow unmasked", 0, 9'd300, 24'h800000, 3'b000, 2'b00);
    op("R9 exact no exc",   0, 9'd100, 24'h900000, 3'b000, 2'b00);
    repeat (3) @(negedge clk);
    wr(2'b10, 3'b000, 3'b000, 4'h0);
    op("R8 reserved 10",    0, 9'd127, 24'h800001, 3'b110, 2'b00);
    repeat (3) @(negedge clk);
    wr(2'b11, 3'b010, 3'b000, 4'h0);
    op("R8 reserved 11",    1, 9'd300, 24'h800000, 3'b000, 2'b00);
    repeat (4) @(negedge clk);
    check("R9 queue drained", q.size(), 32'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule